// File: doc/BRIEF.md
# HDLC Receive Address Filter

This block sits on a multi-channel HDLC receive path, after flag removal and zero-bit deletion. For each frame it inspects the leading one or two address bytes and either forwards the whole frame or drops it silently. Every channel owns four enable bits in a small table, written through a one-cycle configuration strobe. A shared 16-bit match word provides the two programmed address bytes: the low byte is compared with the first byte and the high byte with the second. The all-ones pattern serves as a broadcast address for either position.

Input bytes arrive one per strobe. `in_sof` marks the first byte of a frame, `in_eof` marks the last, and `in_chan` on the first byte names the channel. The source is a bit-serial deframer, so `in_valid` is never high on two consecutive cycles. A frame is held back until its address verdict is known, so no byte of a dropped frame ever reaches the output. One cycle after the decision, the block pulses `out_accept` together with the first forwarded byte, or pulses `out_drop` on its own.

The controller has five states. IDLE waits for a start byte. HOLD1 holds the first byte while the second byte is awaited. SEND2 emits the held second byte. PASS forwards the body of an accepted frame. DROP discards bytes until the end of the frame. Any start byte, in any state, evaluates the first-byte check. A failed check goes to DROP, or to IDLE if the byte also ends the frame. A pass goes to HOLD1 when a second-byte check is enabled, and otherwise goes to PASS (or IDLE) and emits the byte. From HOLD1, a passing byte goes to SEND2 and a failing byte goes to DROP or IDLE. SEND2 goes to PASS, or to IDLE if the held byte ended the frame. PASS goes to IDLE on an end byte, and so does DROP.

Top module: `hdlc_addr_filter`

## Requirements
- R1: After reset all outputs are low and every channel's enable bits are zero, so every frame is forwarded byte for byte.
- R2: Enable bit 0 of a channel requires the first byte to equal `match_word[7:0]`.
- R3: Enable bit 1 of a channel requires the first byte to equal 8'hFF.
- R4: Enable bit 2 of a channel requires the second byte to equal `match_word[15:8]`.
- R5: Enable bit 3 of a channel requires the second byte to equal 8'hFF.
- R6: When both enables for one byte position are set, either match accepts that position. When neither is set, the position is not checked.
- R7: A dropped frame produces no output byte and exactly one `out_drop` pulse. An accepted frame produces exactly one `out_accept` pulse, in the cycle of its `out_sof` byte, and `out_accept` and `out_drop` are never high together.
- R8: A frame that ends before every enabled address byte has arrived is dropped. A one-byte frame that passes a first-byte-only check is forwarded with both `out_sof` and `out_eof` set.
- R9: The enable table holds one entry per channel. It is written with `cfg_en` at index `cfg_chan` when `cfg_we` is high. The entry named by `in_chan` on the start byte governs the frame, and `out_chan` carries that channel.
- R10: If no second-byte check applies, each forwarded byte appears one cycle after its input strobe. If a second-byte check applies, the first byte appears one cycle after the second byte's strobe, and the second byte appears in the cycle after that.
- R11: Bytes that arrive without `in_sof` while no frame is open are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the enable table |
| cfg_chan | input | 5 | Channel index to write |
| cfg_en | input | 4 | Enable bits: 0 first=low match byte, 1 first=FF, 2 second=high match byte, 3 second=FF |
| match_word | input | 16 | Programmed address bytes (low byte first position, high byte second) |
| in_valid | input | 1 | Input byte strobe, never on consecutive cycles |
| in_sof | input | 1 | Input byte is the first of a frame |
| in_eof | input | 1 | Input byte is the last of a frame |
| in_chan | input | 5 | Channel of the frame, sampled with the start byte |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte strobe |
| out_sof | output | 1 | Output byte is the first of a frame |
| out_eof | output | 1 | Output byte is the last of a frame |
| out_chan | output | 5 | Channel of the forwarded frame |
| out_data | output | 8 | Forwarded byte |
| out_accept | output | 1 | One-cycle pulse: frame accepted |
| out_drop | output | 1 | One-cycle pulse: frame dropped |

## Verification
A corrupted controller state shows up at the ports within one or two byte strobes. A stuck HOLD1 or DROP makes a frame that should pass vanish with no `out_accept`. A missed transition into SEND2 loses the second byte, so the frame comes out one byte short. Stray body bytes with no open frame, or an accept pulse that does not sit on a start byte, are caught by the bound checker in the cycle they occur. Latched enable bits that are wrong flip the verdict of the very next frame on that channel, and the per-frame byte, count and pulse comparisons expose this.

// File: rtl/hdlc_af_pkg.sv
package hdlc_af_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD1,
        ST_SEND2,
        ST_PASS,
        ST_DROP
    } af_state_e;

    typedef struct packed {
        logic sec_bc;
        logic sec_val;
        logic first_bc;
        logic first_val;
    } af_en_t;

endpackage

// File: rtl/hdlc_af_cfg_table.sv
module hdlc_af_cfg_table
    import hdlc_af_pkg::*;
#(
    parameter int ENTRIES = 32,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  af_en_t           wr_val,
    input  logic [IDX_W-1:0] rd_idx,
    output af_en_t           rd_val
);

    af_en_t entry_q [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entry_q[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                entry_q[g] <= wr_val;
            end
        end
    end

    assign rd_val = entry_q[rd_idx];

endmodule

// File: rtl/hdlc_af_byte_match.sv
module hdlc_af_byte_match #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] byte_in,
    input  logic [DATA_W-1:0] ref_val,
    input  logic              en_val,
    input  logic              en_bc,
    output logic              ok
);

    logic hit_val;
    logic hit_bc;

    assign hit_val = en_val && (byte_in == ref_val);
    assign hit_bc  = en_bc && (byte_in == {DATA_W{1'b1}});
    assign ok      = !(en_val || en_bc) || hit_val || hit_bc;

endmodule

// File: rtl/hdlc_addr_filter.sv
module hdlc_addr_filter
    import hdlc_af_pkg::*;
#(
    parameter int CHANNELS = 32,
    parameter int DATA_W = 8,
    localparam int CH_W = $clog2(CHANNELS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [CH_W-1:0]     cfg_chan,
    input  logic [3:0]          cfg_en,
    input  logic [2*DATA_W-1:0] match_word,
    input  logic                in_valid,
    input  logic                in_sof,
    input  logic                in_eof,
    input  logic [CH_W-1:0]     in_chan,
    input  logic [DATA_W-1:0]   in_data,
    output logic                out_valid,
    output logic                out_sof,
    output logic                out_eof,
    output logic [CH_W-1:0]     out_chan,
    output logic [DATA_W-1:0]   out_data,
    output logic                out_accept,
    output logic                out_drop
);

    af_state_e st_q, st_nxt;
    af_en_t    tbl_en, en_q;
    logic      pass1, pass2, need2;

    logic [DATA_W-1:0] hold1_q, hold2_q;
    logic              hold2_eof_q;
    logic [CH_W-1:0]   chan_q;

    logic              emit, e_sof, e_eof, acc, drp;
    logic [DATA_W-1:0] e_data;
    logic [CH_W-1:0]   e_chan;
    logic              ld_en, ld_h1, ld_h2;

    hdlc_af_cfg_table #(.ENTRIES(CHANNELS)) u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_we),
        .wr_idx (cfg_chan),
        .wr_val (af_en_t'(cfg_en)),
        .rd_idx (in_chan),
        .rd_val (tbl_en)
    );

    hdlc_af_byte_match #(.DATA_W(DATA_W)) u_match_first (
        .byte_in (in_data),
        .ref_val (match_word[DATA_W-1:0]),
        .en_val  (tbl_en.first_val),
        .en_bc   (tbl_en.first_bc),
        .ok      (pass1)
    );

    hdlc_af_byte_match #(.DATA_W(DATA_W)) u_match_second (
        .byte_in (in_data),
        .ref_val (match_word[2*DATA_W-1:DATA_W]),
        .en_val  (en_q.sec_val),
        .en_bc   (en_q.sec_bc),
        .ok      (pass2)
    );

    assign need2 = tbl_en.sec_val || tbl_en.sec_bc;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nxt;
    end

    // Next state and emit decision
    always_comb begin
        st_nxt = st_q;
        emit   = 1'b0;
        e_data = in_data;
        e_sof  = 1'b0;
        e_eof  = 1'b0;
        e_chan = chan_q;
        acc    = 1'b0;
        drp    = 1'b0;
        ld_en  = 1'b0;
        ld_h1  = 1'b0;
        ld_h2  = 1'b0;
        if (in_valid && in_sof) begin
            ld_en = 1'b1;
            if (!pass1) begin
                drp    = 1'b1;
                st_nxt = in_eof ? ST_IDLE : ST_DROP;
            end else if (need2) begin
                if (in_eof) begin
                    drp    = 1'b1;
                    st_nxt = ST_IDLE;
                end else begin
                    ld_h1  = 1'b1;
                    st_nxt = ST_HOLD1;
                end
            end else begin
                emit   = 1'b1;
                e_sof  = 1'b1;
                e_eof  = in_eof;
                e_chan = in_chan;
                acc    = 1'b1;
                st_nxt = in_eof ? ST_IDLE : ST_PASS;
            end
        end else begin
            unique case (st_q)
                ST_IDLE: ;
                ST_HOLD1: begin
                    if (in_valid) begin
                        if (pass2) begin
                            emit   = 1'b1;
                            e_data = hold1_q;
                            e_sof  = 1'b1;
                            acc    = 1'b1;
                            ld_h2  = 1'b1;
                            st_nxt = ST_SEND2;
                        end else begin
                            drp    = 1'b1;
                            st_nxt = in_eof ? ST_IDLE : ST_DROP;
                        end
                    end
                end
                ST_SEND2: begin
                    emit   = 1'b1;
                    e_data = hold2_q;
                    e_eof  = hold2_eof_q;
                    st_nxt = hold2_eof_q ? ST_IDLE : ST_PASS;
                end
                ST_PASS: begin
                    if (in_valid) begin
                        emit  = 1'b1;
                        e_eof = in_eof;
                        if (in_eof) st_nxt = ST_IDLE;
                    end
                end
                ST_DROP: begin
                    if (in_valid && in_eof) st_nxt = ST_IDLE;
                end
                default: st_nxt = ST_IDLE;
            endcase
        end
    end

    // Output and holding registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_sof     <= 1'b0;
            out_eof     <= 1'b0;
            out_chan    <= '0;
            out_data    <= '0;
            out_accept  <= 1'b0;
            out_drop    <= 1'b0;
            en_q        <= '0;
            chan_q      <= '0;
            hold1_q     <= '0;
            hold2_q     <= '0;
            hold2_eof_q <= 1'b0;
        end else begin
            out_valid  <= emit;
            out_sof    <= emit && e_sof;
            out_eof    <= emit && e_eof;
            out_accept <= acc;
            out_drop   <= drp;
            if (emit) begin
                out_data <= e_data;
                out_chan <= e_chan;
            end
            if (ld_en) begin
                en_q   <= tbl_en;
                chan_q <= in_chan;
            end
            if (ld_h1) hold1_q <= in_data;
            if (ld_h2) begin
                hold2_q     <= in_data;
                hold2_eof_q <= in_eof;
            end
        end
    end

endmodule

// File: rtl/hdlc_af_checker.sv
module hdlc_af_checker (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_sof,
    input logic in_eof,
    input logic out_valid,
    input logic out_sof,
    input logic out_eof,
    input logic out_accept,
    input logic out_drop
);

    logic open_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                    open_q <= 1'b0;
        else if (out_valid && out_sof) open_q <= !out_eof;
        else if (out_valid && out_eof) open_q <= 1'b0;
    end

    assert_marks_need_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sof || out_eof) |-> out_valid);

    assert_verdict_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_accept && out_drop));

    assert_accept_on_sof_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_accept == out_sof);

    assert_body_inside_frame_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_sof) |-> open_q);

    assert_body_timing_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_sof) |-> ($past(in_valid) || $past(out_sof)));

    assert_single_byte_whole_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sof && in_eof) |=> (!out_valid || (out_sof && out_eof)));

endmodule

bind hdlc_addr_filter hdlc_af_checker u_af_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_sof     (in_sof),
    .in_eof     (in_eof),
    .out_valid  (out_valid),
    .out_sof    (out_sof),
    .out_eof    (out_eof),
    .out_accept (out_accept),
    .out_drop   (out_drop)
);

// File: tb/tb_hdlc_addr_filter.sv
module tb_hdlc_addr_filter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_chan = '0;
    logic [3:0]  cfg_en = '0;
    logic [15:0] match_word = 16'hA55C;
    logic        in_valid = 1'b0;
    logic        in_sof = 1'b0;
    logic        in_eof = 1'b0;
    logic [4:0]  in_chan = '0;
    logic [7:0]  in_data = '0;
    logic        out_valid, out_sof, out_eof, out_accept, out_drop;
    logic [4:0]  out_chan;
    logic [7:0]  out_data;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    hdlc_addr_filter dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_chan(cfg_chan),
        .cfg_en(cfg_en), .match_word(match_word), .in_valid(in_valid),
        .in_sof(in_sof), .in_eof(in_eof), .in_chan(in_chan), .in_data(in_data),
        .out_valid(out_valid), .out_sof(out_sof), .out_eof(out_eof),
        .out_chan(out_chan), .out_data(out_data), .out_accept(out_accept),
        .out_drop(out_drop)
    );

    // Monitor: records forwarded bytes and verdict pulses
    logic [7:0] mon_data [64];
    logic       mon_sof  [64];
    logic       mon_eof  [64];
    logic [4:0] mon_chan [64];
    int mon_n = 0;
    int acc_n = 0;
    int drp_n = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                mon_data[mon_n % 64] = out_data;
                mon_sof[mon_n % 64]  = out_sof;
                mon_eof[mon_n % 64]  = out_eof;
                mon_chan[mon_n % 64] = out_chan;
                mon_n++;
            end
            if (out_accept) acc_n++;
            if (out_drop)   drp_n++;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic program_chan(input logic [4:0] ch, input logic [3:0] en);
        @(negedge clk);
        cfg_we = 1'b1; cfg_chan = ch; cfg_en = en;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic put_byte(input logic [4:0] ch, input logic [7:0] d,
                            input logic s, input logic e);
        @(negedge clk);
        in_valid = 1'b1; in_chan = ch; in_data = d; in_sof = s; in_eof = e;
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    endtask

    function automatic logic [7:0] byte_at(input int i, input logic [7:0] b0,
                                           input logic [7:0] b1);
        if (i == 0) return b0;
        if (i == 1) return b1;
        return 8'h30 + 8'(i);
    endfunction

    task automatic run_frame(input string tag, input logic [4:0] ch, input logic [3:0] en,
                             input int len, input logic [7:0] b0, input logic [7:0] b1,
                             input bit exp);
        int n0, a0, d0, got;
        program_chan(ch, en);
        n0 = mon_n; a0 = acc_n; d0 = drp_n;
        for (int i = 0; i < len; i++)
            put_byte(ch, byte_at(i, b0, b1), i == 0, i == len - 1);
        repeat (3) @(negedge clk);
        got = mon_n - n0;
        chk(acc_n - a0 == int'(exp), {tag, " accept pulses"}, acc_n - a0, int'(exp));
        chk(drp_n - d0 == int'(!exp), {tag, " drop pulses"}, drp_n - d0, int'(!exp));
        chk(got == (exp ? len : 0), {tag, " byte count"}, got, exp ? len : 0);
        if (exp && got == len) begin
            for (int i = 0; i < len; i++) begin
                int k;
                k = (n0 + i) % 64;
                chk(mon_data[k] == byte_at(i, b0, b1), {tag, " data"},
                    int'(mon_data[k]), int'(byte_at(i, b0, b1)));
                chk(mon_sof[k] == (i == 0), {tag, " sof"}, int'(mon_sof[k]), int'(i == 0));
                chk(mon_eof[k] == (i == len - 1), {tag, " eof"},
                    int'(mon_eof[k]), int'(i == len - 1));
                chk(mon_chan[k] == ch, {tag, " chan"}, int'(mon_chan[k]), int'(ch));
            end
        end
    endtask

    // {chan[28:24], en[23:20], len[19:17], b0[16:9], b1[8:1], accept[0]}
    localparam logic [28:0] VEC [22] = '{
        {5'd0,  4'b0000, 3'd3, 8'h12, 8'h34, 1'b1},
        {5'd1,  4'b0001, 3'd3, 8'h5C, 8'h00, 1'b1},
        {5'd1,  4'b0001, 3'd3, 8'h5D, 8'h00, 1'b0},
        {5'd2,  4'b0010, 3'd2, 8'hFF, 8'h11, 1'b1},
        {5'd2,  4'b0010, 3'd2, 8'h5C, 8'h11, 1'b0},
        {5'd3,  4'b0100, 3'd3, 8'h77, 8'hA5, 1'b1},
        {5'd3,  4'b0100, 3'd3, 8'h77, 8'hA4, 1'b0},
        {5'd4,  4'b1000, 3'd2, 8'h01, 8'hFF, 1'b1},
        {5'd4,  4'b1000, 3'd2, 8'h01, 8'hA5, 1'b0},
        {5'd5,  4'b0011, 3'd2, 8'hFF, 8'h00, 1'b1},
        {5'd5,  4'b0011, 3'd2, 8'h5C, 8'h00, 1'b1},
        {5'd5,  4'b0011, 3'd2, 8'h00, 8'h00, 1'b0},
        {5'd6,  4'b1100, 3'd3, 8'h00, 8'hA5, 1'b1},
        {5'd6,  4'b1100, 3'd3, 8'h00, 8'hFF, 1'b1},
        {5'd6,  4'b1100, 3'd3, 8'h00, 8'hFE, 1'b0},
        {5'd7,  4'b0101, 3'd3, 8'h5C, 8'hA5, 1'b1},
        {5'd7,  4'b0101, 3'd3, 8'h5C, 8'h00, 1'b0},
        {5'd7,  4'b0101, 3'd3, 8'h11, 8'hA5, 1'b0},
        {5'd31, 4'b0101, 3'd4, 8'h5C, 8'hA5, 1'b1},
        {5'd4,  4'b1000, 3'd1, 8'h01, 8'h00, 1'b0},
        {5'd1,  4'b0001, 3'd1, 8'h5C, 8'h00, 1'b1},
        {5'd3,  4'b0100, 3'd2, 8'h77, 8'hA5, 1'b1}
    };

    string tags [22] = '{"R1", "R2", "R2", "R3", "R3", "R4", "R4", "R5", "R5",
                         "R6", "R6", "R6", "R6", "R6", "R6", "R7", "R7", "R7",
                         "R9", "R8", "R8", "R10"};

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!out_valid && !out_accept && !out_drop, "R1 reset outputs",
            {out_valid, out_accept, out_drop}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < 22; i++) begin
            logic [28:0] v;
            v = VEC[i];
            run_frame(tags[i], v[28:24], v[23:20], int'(v[19:17]), v[16:9], v[8:1], v[0]);
        end

        // R9: neighbouring channels keep separate enables
        program_chan(5'd8, 4'b0001);
        run_frame("R9 chan9 unchecked", 5'd9, 4'b0000, 2, 8'h00, 8'h01, 1'b1);
        n_check_chan8: begin
            int d0;
            d0 = drp_n;
            put_byte(5'd8, 8'h00, 1'b1, 1'b1);
            repeat (2) @(negedge clk);
            chk(drp_n - d0 == 1, "R9 chan8 keeps its enable", drp_n - d0, 1);
        end

        // R11: stray byte with no open frame
        begin
            int n0, a0, d0;
            n0 = mon_n; a0 = acc_n; d0 = drp_n;
            put_byte(5'd0, 8'h42, 1'b0, 1'b0);
            put_byte(5'd0, 8'h43, 1'b0, 1'b1);
            repeat (2) @(negedge clk);
            chk(mon_n == n0, "R11 stray bytes ignored", mon_n - n0, 0);
            chk(acc_n == a0 && drp_n == d0, "R11 no verdict", acc_n - a0 + drp_n - d0, 0);
        end

        // R10: exact output timing, first-byte-only decision
        program_chan(5'd10, 4'b0000);
        @(negedge clk);
        in_valid = 1'b1; in_chan = 5'd10; in_data = 8'h9A; in_sof = 1'b1; in_eof = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        chk(out_valid && out_sof && out_eof && out_data == 8'h9A, "R10 one-cycle forward",
            int'(out_data), 8'h9A);
        repeat (2) @(negedge clk);

        // R10: second-byte decision timing
        program_chan(5'd11, 4'b0100);
        @(negedge clk);
        in_valid = 1'b1; in_chan = 5'd11; in_data = 8'h66; in_sof = 1'b1; in_eof = 1'b0;
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0;
        chk(!out_valid, "R10 first byte held", int'(out_valid), 0);
        @(negedge clk);
        in_valid = 1'b1; in_data = 8'hA5; in_eof = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; in_eof = 1'b0;
        chk(out_valid && out_sof && out_accept && out_data == 8'h66, "R10 held byte out",
            int'(out_data), 8'h66);
        @(negedge clk);
        chk(out_valid && out_eof && !out_sof && out_data == 8'hA5, "R10 second byte next",
            int'(out_data), 8'hA5);
        repeat (2) @(negedge clk);

        // R1: reset clears the enable table
        program_chan(5'd12, 4'b0001);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(!out_valid && !out_accept && !out_drop, "R1 outputs after reset",
            {out_valid, out_accept, out_drop}, 0);
        rst_n = 1'b1;
        begin
            int a0;
            a0 = acc_n;
            put_byte(5'd12, 8'h00, 1'b1, 1'b1);
            repeat (2) @(negedge clk);
            chk(acc_n - a0 == 1, "R1 table cleared by reset", acc_n - a0, 1);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule